// File: doc/BRIEF.md
# Text-Mode VGA Display Controller

This block produces a 640x480, 60 Hz VGA picture from a 25 MHz pixel clock. The picture is an 80-column screen of monochrome text. A processor fills a character store with byte codes and the store is scanned out every frame. Each cell is 8 pixels wide and 16 scanlines tall, so the default screen has 30 rows and uses 2400 bytes. The cell at text row `r` and column `c` is held at byte `r*COLS + c` above the store's base address.

The processor side runs on its own clock. It has a write-only port into the character store, decoded from a 16-bit data address, and one control byte on an 8-bit I/O address. The control byte picks the single foreground colour used for all text and enables a once-per-frame interrupt. It also reports whether the pixel clock source has locked. Glyph shapes come from a rule computed inside the block, not from stored font data. Software draws a cursor by writing an ordinary character.

Top module: `vga_text_ctrl`

## Requirements
- R1: `hsync_n` repeats every H_TOTAL = H_VIS+H_FP+H_SYNC+H_BP pixel clocks. It is low for H_SYNC clocks, starting H_FP clocks after the last visible pixel of a line.
- R2: `vsync_n` repeats every V_TOTAL lines. It is low for V_SYNC whole lines, starting V_FP lines after the last visible line. It changes only at the first pixel position of a line, while `hsync_n` is high.
- R3: Outside the visible H_VIS x V_VIS area, `pix_rgb` is 3'b000.
- R4: The visible pixel (x, y) takes the code at cell index (y/16)*COLS + x/8. It shows the current colour if bit 7-(x mod 8) of that code's glyph row (y mod 16) is 1, and shows 000 otherwise.
- R5: The glyph row is 8'h00 when the code is at most 8'h20 or is 8'h7F, and also on scanlines 0 and 15. In every other case it is the code rotated left by (scanline mod 8) bits.
- R6: A `buf_we` write lands in the store only if BUF_BASE <= `buf_addr` < BUF_BASE+COLS*ROWS. A write to any other address changes nothing on screen.
- R7: A write to I/O address CTRL_ADDR (8'h80) sets the interrupt enable from bit 3. It sets the colour from bits 2:0 (bit 2 red, bit 1 green, bit 0 blue), except that a colour value of 000 is ignored and the previous colour is kept.
- R8: A read at CTRL_ADDR returns {lock, 3'b000, enable, colour}. Any other I/O address reads 8'h00. After reset the colour is 111 and the enable is 0.
- R9: With the enable set, `irq` gives exactly one single-cycle pulse per frame, after the last visible line ends and before the vertical sync. With the enable clear, `irq` stays low.
- R10: The lock bit (bit 7 of the control byte) follows `pll_locked` after two processor-clock synchronizer stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Processor-side clock |
| pix_clk | input | 1 | Pixel clock (25 MHz in the default timing) |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| buf_we | input | 1 | Character store write strobe |
| buf_addr | input | 16 | Data address of the write |
| buf_wdata | input | 8 | Character code to store |
| io_we | input | 1 | I/O write strobe |
| io_addr | input | 8 | I/O address, for both read and write |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | Control byte read data |
| irq | output | 1 | Frame-end interrupt pulse, processor domain |
| pll_locked | input | 1 | Asynchronous lock indication from the clock source |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| pix_rgb | output | 3 | Pixel colour {red, green, blue} |

## Verification
If a scan counter slips, the sync spacing changes, and a checker that locks on to the first vertical sync edge then finds a wrong pulse within one line. A wrong store index or glyph slice shows up as a wrong lit pixel on the first visible line that follows. Faults in the colour or enable register show up as soon as the byte is read back. An error in interrupt gating or edge detection gives a pulse count other than one inside a single vsync-to-vsync window.

// File: rtl/vga_text_ctrl.sv
module vga_text_ctrl #(
  parameter int H_VIS = 640,
  parameter int H_FP = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP = 48,
  parameter int V_VIS = 480,
  parameter int V_FP = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP = 33,
  parameter logic [15:0] BUF_BASE = 16'h2000,
  parameter logic [7:0] CTRL_ADDR = 8'h80
) (
  input  logic       cpu_clk,
  input  logic       pix_clk,
  input  logic       rst_n,
  input  logic       buf_we,
  input  logic [15:0] buf_addr,
  input  logic [7:0] buf_wdata,
  input  logic       io_we,
  input  logic [7:0] io_addr,
  input  logic [7:0] io_wdata,
  output logic [7:0] io_rdata,
  output logic       irq,
  input  logic       pll_locked,
  output logic       hsync_n,
  output logic       vsync_n,
  output logic [2:0] pix_rgb
);
  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int COLS = H_VIS / 8;
  localparam int ROWS = V_VIS / 16;
  localparam int DEPTH = COLS * ROWS;
  localparam int AW = $clog2(DEPTH);
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
  localparam logic [HW-1:0] HS_BEG = HW'(H_VIS + H_FP);
  localparam logic [HW-1:0] HS_END = HW'(H_VIS + H_FP + H_SYNC);
  localparam logic [VW-1:0] VS_BEG = VW'(V_VIS + V_FP);
  localparam logic [VW-1:0] VS_END = VW'(V_VIS + V_FP + V_SYNC);

  function automatic logic [7:0] glyph_row(input logic [7:0] code, input logic [3:0] line);
    logic [15:0] dbl;
    dbl = {code, code} << line[2:0];
    if (code <= 8'h20 || code == 8'h7F || line == 4'd0 || line == 4'd15)
      return 8'h00;
    return dbl[15:8];
  endfunction

  logic [7:0] mem [DEPTH];

  // ---------------- processor domain ----------------
  logic [2:0] colour_q;
  logic       irq_en;
  logic [1:0] lk_s;
  logic [2:0] tgl_s;
  logic       frame_tgl;
  logic       ctl_hit;
  logic [15:0] wr_off;
  logic       wr_hit;

  assign ctl_hit = io_addr == CTRL_ADDR;
  assign io_rdata = ctl_hit ? {lk_s[1], 3'b000, irq_en, colour_q} : 8'h00;
  assign wr_off = buf_addr - BUF_BASE;
  assign wr_hit = buf_we && buf_addr >= BUF_BASE && wr_off < 16'(DEPTH);

  always_ff @(posedge cpu_clk or negedge rst_n) begin
    if (!rst_n) begin
      colour_q <= 3'b111;
      irq_en <= 1'b0;
    end else if (io_we && ctl_hit) begin
      irq_en <= io_wdata[3];
      if (io_wdata[2:0] != 3'b000) colour_q <= io_wdata[2:0];
    end
  end

  always_ff @(posedge cpu_clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_s <= '0;
      tgl_s <= '0;
      irq <= 1'b0;
    end else begin
      lk_s <= {lk_s[0], pll_locked};
      tgl_s <= {tgl_s[1:0], frame_tgl};
      irq <= (tgl_s[2] ^ tgl_s[1]) & irq_en;
    end
  end

  always_ff @(posedge cpu_clk) begin
    if (wr_hit) mem[wr_off[AW-1:0]] <= buf_wdata;
  end

  p_colour_legal_r7: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    colour_q != 3'b000);
  p_irq_pulse_r9: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    irq |=> !irq);
  p_irq_gate_r9: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    irq |-> $past(irq_en));

  // ---------------- pixel domain ----------------
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic [2:0] col_a, col_b;
  logic vis0, hs0, vs0;
  logic [AW-1:0] rd_addr;
  logic [7:0] code_q;
  logic [2:0] hl1;
  logic [3:0] vl1;
  logic vis1, hs1, vs1;
  logic [7:0] gbits;
  logic lit;

  assign vis0 = hcnt < HW'(H_VIS) && vcnt < VW'(V_VIS);
  assign hs0 = !(hcnt >= HS_BEG && hcnt < HS_END);
  assign vs0 = !(vcnt >= VS_BEG && vcnt < VS_END);
  assign rd_addr = AW'(32'(hcnt >> 3) + 32'(vcnt >> 4) * 32'(COLS));
  assign gbits = glyph_row(code_q, vl1);
  assign lit = gbits[3'd7 - hl1];

  always_ff @(posedge pix_clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
      frame_tgl <= 1'b0;
    end else begin
      hcnt <= (hcnt == H_LAST) ? '0 : hcnt + 1'b1;
      if (hcnt == H_LAST) begin
        vcnt <= (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
        if (vcnt == VW'(V_VIS - 1)) frame_tgl <= ~frame_tgl;
      end
    end
  end

  always_ff @(posedge pix_clk or negedge rst_n) begin
    if (!rst_n) begin
      col_a <= 3'b111;
      col_b <= 3'b111;
      hl1 <= '0;
      vl1 <= '0;
      vis1 <= 1'b0;
      hs1 <= 1'b1;
      vs1 <= 1'b1;
      pix_rgb <= '0;
      hsync_n <= 1'b1;
      vsync_n <= 1'b1;
    end else begin
      col_a <= colour_q;
      col_b <= col_a;
      hl1 <= hcnt[2:0];
      vl1 <= vcnt[3:0];
      vis1 <= vis0;
      hs1 <= hs0;
      vs1 <= vs0;
      pix_rgb <= (vis1 && lit) ? col_b : 3'b000;
      hsync_n <= hs1;
      vsync_n <= vs1;
    end
  end

  always_ff @(posedge pix_clk) begin
    if (vis0) code_q <= mem[rd_addr];
  end

  p_hcnt_step_r1: assert property (@(posedge pix_clk) disable iff (!rst_n)
    hcnt != H_LAST |=> hcnt == $past(hcnt) + 1'b1);
  p_hcnt_wrap_r1: assert property (@(posedge pix_clk) disable iff (!rst_n)
    hcnt == H_LAST |=> hcnt == '0);
  p_vsync_edge_r2: assert property (@(posedge pix_clk) disable iff (!rst_n)
    !$stable(vsync_n) |-> hsync_n);
  p_blank_dark_r3: assert property (@(posedge pix_clk) disable iff (!rst_n)
    (!hsync_n || !vsync_n) |-> pix_rgb == 3'b000);
endmodule

// File: tb/sim_vga_text_ctrl.sv
module sim_vga_text_ctrl;
  localparam int HV = 64, HF = 4, HS = 8, HB = 4;
  localparam int VV = 32, VF = 2, VS = 2, VB = 3;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam int COLS = HV / 8;
  localparam int DEPTH = COLS * (VV / 16);
  localparam logic [15:0] BASE = 16'h2000;
  localparam logic [7:0] CADDR = 8'h80;

  logic cpu_clk = 0, pix_clk = 0, rst_n = 0;
  logic buf_we = 0, io_we = 0, pll_locked = 0;
  logic [15:0] buf_addr = 0;
  logic [7:0] buf_wdata = 0, io_addr = 0, io_wdata = 0;
  logic [7:0] io_rdata;
  logic irq, hsync_n, vsync_n;
  logic [2:0] pix_rgb;

  int vectors = 0, fails = 0;
  int irq_cnt = 0, irq_dbl = 0;
  logic irq_prev = 0;
  logic [7:0] bmem [DEPTH];
  logic [2:0] colour = 3'b111;

  always #2 cpu_clk = ~cpu_clk;
  always #4 pix_clk = ~pix_clk;

  vga_text_ctrl #(.H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
                  .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)) u0 (
    .cpu_clk(cpu_clk), .pix_clk(pix_clk), .rst_n(rst_n),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .irq(irq), .pll_locked(pll_locked),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .pix_rgb(pix_rgb));

  always @(negedge cpu_clk) begin
    if (irq && irq_prev) irq_dbl++;
    if (irq) irq_cnt++;
    irq_prev <= irq;
  end

  function automatic logic [7:0] glyph(input logic [7:0] c, input int line);
    logic [7:0] r;
    if (c <= 8'h20 || c == 8'h7F || line == 0 || line == 15) return 8'h00;
    r = c;
    for (int k = 0; k < line % 8; k++) r = {r[6:0], r[7]};
    return r;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic buf_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge cpu_clk);
    buf_addr = a; buf_wdata = d; buf_we = 1;
    @(negedge cpu_clk);
    buf_we = 0;
  endtask

  task automatic io_write(input logic [7:0] d);
    @(negedge cpu_clk);
    io_addr = CADDR; io_wdata = d; io_we = 1;
    @(negedge cpu_clk);
    io_we = 0;
  endtask

  task automatic io_read(input logic [7:0] a, input int exp, input string req);
    @(negedge cpu_clk);
    io_addr = a;
    @(negedge cpu_clk);
    check(req, io_rdata, exp);
    io_addr = CADDR;
  endtask

  task automatic wait_vfall();
    logic prev;
    prev = vsync_n;
    forever begin
      @(negedge pix_clk);
      if (prev && !vsync_n) break;
      prev = vsync_n;
    end
  endtask

  task automatic check_frames(input int n);
    int h, v;
    wait_vfall();
    h = 0; v = VV + VF;
    for (int i = 0; i < n * VT * HT; i++) begin
      logic eh, ev;
      logic [2:0] er;
      eh = !(h >= HV + HF && h < HV + HF + HS);
      ev = !(v >= VV + VF && v < VV + VF + VS);
      er = 3'b000;
      if (h < HV && v < VV) begin
        logic [7:0] g;
        g = glyph(bmem[(v / 16) * COLS + h / 8], v % 16);
        if (g[7 - h % 8]) er = colour;
      end
      vectors++;
      if (hsync_n !== eh || vsync_n !== ev || pix_rgb !== er) begin
        fails++;
        if (hsync_n !== eh) $display("FAIL R1 hsync at (%0d,%0d) actual=%0b expected=%0b", h, v, hsync_n, eh);
        if (vsync_n !== ev) $display("FAIL R2 vsync at (%0d,%0d) actual=%0b expected=%0b", h, v, vsync_n, ev);
        if (pix_rgb !== er)
          $display("FAIL %s rgb at (%0d,%0d) actual=%0d expected=%0d",
                   (h < HV && v < VV) ? "R4 R5" : "R3", h, v, pix_rgb, er);
      end
      h++;
      if (h == HT) begin h = 0; v = (v + 1) % VT; end
      @(negedge pix_clk);
    end
  endtask

  task automatic irq_window(input int exp);
    int b;
    wait_vfall();
    b = irq_cnt;
    wait_vfall();
    check("R9 irq pulses per frame", irq_cnt - b, exp);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    io_addr = CADDR;
    repeat (4) @(negedge cpu_clk);
    check("R8 reset ctrl", io_rdata, 8'h07);
    check("R1 reset hsync", hsync_n, 1);
    check("R2 reset vsync", vsync_n, 1);
    check("R3 reset rgb", pix_rgb, 0);
    check("R9 reset irq", irq, 0);
    rst_n = 1;
    repeat (4) @(negedge cpu_clk);
    check("R10 unlocked", io_rdata, 8'h07);
    pll_locked = 1;
    @(negedge cpu_clk);
    check("R10 one stage", io_rdata[7], 0);
    @(negedge cpu_clk);
    check("R10 locked", io_rdata, 8'h87);
    io_read(8'h81, 8'h00, "R8 other address");

    for (int i = 0; i < DEPTH; i++) begin
      logic [7:0] c;
      c = 8'($urandom);
      case (i)
        0: c = 8'h20;
        1: c = 8'h7F;
        2: c = 8'h00;
        3: c = 8'hFF;
        4: c = 8'h21;
        default: ;
      endcase
      bmem[i] = c;
      buf_write(BASE + 16'(i), c);
    end
    // R6: writes just outside the window must not reach the screen
    buf_write(BASE - 16'd1, 8'h55);
    buf_write(BASE + 16'(DEPTH), 8'h55);
    buf_write(16'h0000, 8'h55);

    io_write(8'h05); colour = 3'b101;
    io_read(CADDR, 8'h85, "R7 colour write");
    io_write(8'h08);
    io_read(CADDR, 8'h8D, "R7 zero colour ignored");
    io_write(8'h05);
    check_frames(2);

    colour = 3'($urandom_range(7, 1));
    io_write({5'b0, colour});
    for (int k = 0; k < 4; k++) begin
      int idx;
      idx = int'($urandom_range(DEPTH - 1, 0));
      bmem[idx] = 8'($urandom_range(255, 33));
      buf_write(BASE + 16'(idx), bmem[idx]);
    end
    bmem[5] = 8'h7E;
    buf_write(BASE + 16'd5, 8'h7E);
    check_frames(1);

    irq_window(0);
    io_write({5'b00001, colour});
    io_read(CADDR, {8'h88 | 8'(colour)}, "R8 enable readback");
    irq_window(1);
    irq_window(1);
    io_write({5'b0, colour});
    irq_window(0);
    check("R9 single-cycle pulses", irq_dbl, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule